// File: doc/BRIEF.md
# Overcurrent and Undervoltage Hiccup Supervisor

This block supervises a switching regulator. It runs on a system clock and advances once per switching cycle, on a one-clock strobe that marks the start of each cycle. It watches an overcurrent comparator, an undervoltage comparator, a junction temperature code and a flag that says the soft-start ramp has finished. From these it drives a high-side cutoff, a regulator shutdown, a request to pull the shared enable line low, a one-clock soft-start restart pulse and an overcurrent condition flag.

An overcurrent cuts the high-side switch within the same switching cycle. The block counts consecutive cycles that contain an overcurrent, and a long enough run of them shuts the regulator down. An undervoltage shuts it down at once, except while overcurrent has already been present for a while; in that case the overcurrent count decides the outcome. After either fault the block holds the enable line low for a hiccup wait of several soft-start periods. It then clears its state and asks for a fresh soft-start. A thermal code comparator with hysteresis keeps the regulator off while the die is hot.

Top module: `hiccup_guard`

## Requirements
- R1: While `ocDet` is high, `hsCut` is high in that same clock. Once `ocDet` has been high in a switching cycle, `hsCut` stays high until the next `cycleStrobe`, and it is low in the clock after that strobe when no other cause holds it.
- R2: At each `cycleStrobe`, the block evaluates the cycle that just ended. If that cycle held an overcurrent, the consecutive count goes up by one and `ocFlag` is high from the next clock on.
- R3: When the eighth consecutive overcurrent cycle is evaluated, `regOff` and `enPullLow` go high in the next clock. Seven consecutive cycles do not shut the regulator down.
- R4: When a cycle with no overcurrent is evaluated while the count is below four, `ocFlag` goes low.
- R5: An undervoltage seen while `ocFlag` is high and fewer than four consecutive overcurrent cycles have been counted shuts the regulator down in the next clock. An undervoltage seen with four or more counted is ignored: `enPullLow` stays low and `ocFlag` stays high.
- R6: With `ocFlag` low and `ssDone` high, `uvDet` high in any clock raises `regOff` and `enPullLow` in the next clock.
- R7: After a fault, `enPullLow` and `regOff` stay high for exactly 4 × SS_CYCLES further strobes, so 12 strobes when SS_CYCLES = 3. They fall at the last of those strobes. At that same point `ssRestart` pulses for exactly one clock and the overcurrent count and `ocFlag` are cleared.
- R8: `tempCode` is an unsigned code in degrees. By default a code of 150 or more sets the hot state, and a code below 130 clears it. Codes in between keep the previous state. The hot state shows on `regOff` one clock later. Leaving the hot state while no fault is active gives exactly one `ssRestart` pulse.
- R9: A cycle with no overcurrent resets the consecutive count to zero, so a run that is interrupted never adds up to a shutdown.
- R10: `uvDet` is ignored while `ssDone` is low.
- R11: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cycleStrobe | input | 1 | One-clock pulse at the start of each switching cycle |
| ocDet | input | 1 | Overcurrent comparator output |
| uvDet | input | 1 | Undervoltage comparator output (feedback below 82 % of reference) |
| ssDone | input | 1 | Soft-start ramp has finished |
| tempCode | input | TEMP_W | Junction temperature code |
| hsCut | output | 1 | Keep the high-side switch off |
| regOff | output | 1 | Regulator shut down |
| enPullLow | output | 1 | Request to pull the shared enable line low |
| ssRestart | output | 1 | One-clock request to start a new soft-start |
| ocFlag | output | 1 | Overcurrent condition flag |

## Verification
Runs of 1 to 10 consecutive overcurrent cycles separate the seven-cycle case, which must not shut down, from the eight-cycle trip. A clean cycle followed by another seven-cycle run shows that the count restarts from zero. Undervoltage is applied after 1 to 5 counted overcurrent cycles, which finds the edge at four between an immediate trip and an ignored undervoltage, and is also applied with no overcurrent and with the ramp still running. The hiccup wait is counted strobe by strobe through both fault paths. A temperature sweep up and back down checks both hysteresis thresholds and the single restart pulse.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  // Strobes from the sequencing control to the counter datapath.
  typedef struct packed {
    logic countEn;   // evaluate the ended switching cycle
    logic clrOc;     // drop the overcurrent count and flag
    logic clrWait;   // restart the hiccup wait
    logic waitStep;  // advance the hiccup wait by one cycle
  } ctlStrb_t;

  typedef enum logic {ST_RUN = 1'b0, ST_HICCUP = 1'b1} supState_t;
endpackage

// File: rtl/hiccup_dp.sv
module hiccup_dp
  import hiccup_pkg::*;
#(
  parameter int OC_TRIP        = 8,
  parameter int SS_CYCLES      = 256,
  parameter int HICCUP_PERIODS = 4,
  parameter int TEMP_W         = 8,
  parameter int TEMP_HOT       = 150,
  parameter int TEMP_COOL      = 130,
  localparam int CNT_W         = $clog2(OC_TRIP + 1),
  localparam int WAIT_LEN      = HICCUP_PERIODS * SS_CYCLES,
  localparam int WAIT_W        = $clog2(WAIT_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleStrobe,
  input  logic              ocDet,
  input  logic [TEMP_W-1:0] tempCode,
  input  ctlStrb_t          ctl,
  output logic              ocHit,
  output logic [CNT_W-1:0]  ocCnt,
  output logic              ocFlag,
  output logic              waitLast,
  output logic              hot
);
  timeunit 1ns;
  timeprecision 100ps;

  logic              ocSeen;
  logic [WAIT_W-1:0] waitCnt;
  logic              tooHot;
  logic              coolEnough;

  assign ocHit      = ocSeen | ocDet;
  assign waitLast   = (waitCnt == WAIT_W'(WAIT_LEN - 1));
  assign tooHot     = (tempCode >= TEMP_W'(TEMP_HOT));
  assign coolEnough = (tempCode <  TEMP_W'(TEMP_COOL));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocSeen  <= 1'b0;
      ocCnt   <= '0;
      ocFlag  <= 1'b0;
      waitCnt <= '0;
      hot     <= 1'b0;
    end else begin
      ocSeen <= cycleStrobe ? 1'b0 : ocHit;

      if (ctl.clrOc) begin
        ocCnt  <= '0;
        ocFlag <= 1'b0;
      end else if (ctl.countEn) begin
        if (ocHit) begin
          if (ocCnt != CNT_W'(OC_TRIP)) ocCnt <= ocCnt + CNT_W'(1);
          ocFlag <= 1'b1;
        end else begin
          ocCnt  <= '0;
          ocFlag <= 1'b0;
        end
      end

      if (ctl.clrWait)       waitCnt <= '0;
      else if (ctl.waitStep) waitCnt <= waitCnt + WAIT_W'(1);

      if (tooHot)          hot <= 1'b1;
      else if (coolEnough) hot <= 1'b0;
    end
  end

  AST_CUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ocDet && !cycleStrobe) |=> ocSeen); // R1
  AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rstN)
    ocCnt <= CNT_W'(OC_TRIP)); // R3
  AST_FLAG_CNT: assert property (@(posedge clk) disable iff (!rstN)
    ocFlag == (ocCnt != '0)); // R2
  AST_HOT_SET: assert property (@(posedge clk) disable iff (!rstN)
    tooHot |=> hot); // R8
  AST_HOT_CLR: assert property (@(posedge clk) disable iff (!rstN)
    coolEnough |=> !hot); // R8
endmodule

// File: rtl/hiccup_ctl.sv
module hiccup_ctl
  import hiccup_pkg::*;
#(
  parameter int OC_TRIP  = 8,
  parameter int OC_EARLY = 4,
  localparam int CNT_W   = $clog2(OC_TRIP + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycleStrobe,
  input  logic             uvDet,
  input  logic             ssDone,
  input  logic             ocHit,
  input  logic [CNT_W-1:0] ocCnt,
  input  logic             ocFlag,
  input  logic             waitLast,
  input  logic             hot,
  output ctlStrb_t         ctl,
  output logic             inHiccup,
  output logic             ssRestart
);
  timeunit 1ns;
  timeprecision 100ps;

  supState_t state;
  logic      hotPrev;
  logic      running;
  logic      countEn;
  logic      ocTrip;
  logic      uvTrip;
  logic      trip;
  logic      leave;

  always_comb begin
    running = (state == ST_RUN);
    countEn = running && cycleStrobe && !hot;
    ocTrip  = countEn && ocHit && (ocCnt == CNT_W'(OC_TRIP - 1));
    uvTrip  = running && !hot && ssDone && uvDet &&
              (!ocFlag || (ocCnt < CNT_W'(OC_EARLY)));
    trip    = ocTrip || uvTrip;
    leave   = !running && cycleStrobe && waitLast;

    ctl.countEn  = countEn;
    ctl.clrOc    = hot || leave;
    ctl.clrWait  = trip;
    ctl.waitStep = !running && cycleStrobe && !waitLast;
  end

  assign inHiccup = (state == ST_HICCUP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_RUN;
      hotPrev   <= 1'b0;
      ssRestart <= 1'b0;
    end else begin
      if (trip)       state <= ST_HICCUP;
      else if (leave) state <= ST_RUN;
      hotPrev   <= hot;
      ssRestart <= leave || (running && hotPrev && !hot);
    end
  end

  AST_UV_TRIP: assert property (@(posedge clk) disable iff (!rstN)
    (running && !hot && ssDone && uvDet && !ocFlag) |=> inHiccup); // R6
  AST_UV_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (running && !ssDone && !(cycleStrobe && ocHit)) |=> !inHiccup); // R10
  AST_HICCUP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (inHiccup && !cycleStrobe) |=> inHiccup); // R7
  AST_RESTART_ONE: assert property (@(posedge clk) disable iff (!rstN)
    ssRestart |=> !ssRestart); // R7
endmodule

// File: rtl/hiccup_guard.sv
module hiccup_guard
  import hiccup_pkg::*;
#(
  parameter int OC_TRIP        = 8,
  parameter int OC_EARLY       = 4,
  parameter int SS_CYCLES      = 256,
  parameter int HICCUP_PERIODS = 4,
  parameter int TEMP_W         = 8,
  parameter int TEMP_HOT       = 150,
  parameter int TEMP_COOL      = 130,
  localparam int CNT_W         = $clog2(OC_TRIP + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleStrobe,
  input  logic              ocDet,
  input  logic              uvDet,
  input  logic              ssDone,
  input  logic [TEMP_W-1:0] tempCode,
  output logic              hsCut,
  output logic              regOff,
  output logic              enPullLow,
  output logic              ssRestart,
  output logic              ocFlag
);
  timeunit 1ns;
  timeprecision 100ps;

  ctlStrb_t         ctl;
  logic             ocHit;
  logic [CNT_W-1:0] ocCnt;
  logic             waitLast;
  logic             hot;
  logic             inHiccup;

  hiccup_dp #(
    .OC_TRIP(OC_TRIP), .SS_CYCLES(SS_CYCLES), .HICCUP_PERIODS(HICCUP_PERIODS),
    .TEMP_W(TEMP_W), .TEMP_HOT(TEMP_HOT), .TEMP_COOL(TEMP_COOL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cycleStrobe(cycleStrobe), .ocDet(ocDet),
    .tempCode(tempCode), .ctl(ctl), .ocHit(ocHit), .ocCnt(ocCnt),
    .ocFlag(ocFlag), .waitLast(waitLast), .hot(hot)
  );

  hiccup_ctl #(.OC_TRIP(OC_TRIP), .OC_EARLY(OC_EARLY)) u_ctl (
    .clk(clk), .rstN(rstN), .cycleStrobe(cycleStrobe), .uvDet(uvDet),
    .ssDone(ssDone), .ocHit(ocHit), .ocCnt(ocCnt), .ocFlag(ocFlag),
    .waitLast(waitLast), .hot(hot), .ctl(ctl), .inHiccup(inHiccup),
    .ssRestart(ssRestart)
  );

  assign regOff    = inHiccup | hot;
  assign enPullLow = inHiccup;
  assign hsCut     = ocHit | regOff;
endmodule

// File: tb/hiccup_guard_tb.sv
module hiccup_guard_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int SSC  = 3;
  localparam int WAIT = 4 * SSC;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cycleStrobe = 1'b0;
  logic       ocDet = 1'b0;
  logic       uvDet = 1'b0;
  logic       ssDone = 1'b1;
  logic [7:0] tempCode = 8'd100;
  logic       hsCut, regOff, enPullLow, ssRestart, ocFlag;

  int total = 0;
  int bad = 0;
  int restartCnt = 0;
  bit done = 1'b0;
  logic cutAtStart;

  hiccup_guard #(.SS_CYCLES(SSC)) u_dut (
    .clk(clk), .rstN(rstN), .cycleStrobe(cycleStrobe), .ocDet(ocDet),
    .uvDet(uvDet), .ssDone(ssDone), .tempCode(tempCode), .hsCut(hsCut),
    .regOff(regOff), .enPullLow(enPullLow), .ssRestart(ssRestart),
    .ocFlag(ocFlag)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rstN && ssRestart) restartCnt++;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cycleStrobe = 1'b0; ocDet = 1'b0; uvDet = 1'b0;
    ssDone = 1'b1; tempCode = 8'd100;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // One switching cycle of four clocks: strobe, event slot, two idle clocks.
  task automatic cyc(input bit oc, input bit uv);
    @(negedge clk); cycleStrobe = 1'b1; ocDet = 1'b0; uvDet = 1'b0;
    @(negedge clk); cycleStrobe = 1'b0; cutAtStart = hsCut; ocDet = oc; uvDet = uv;
    @(negedge clk); ocDet = 1'b0; uvDet = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int rc0;
    bit hotM;
    doReset();
    @(negedge clk);
    chk("R11 hsCut", hsCut, 0);
    chk("R11 regOff", regOff, 0);
    chk("R11 enPullLow", enPullLow, 0);
    chk("R11 ssRestart", ssRestart, 0);
    chk("R11 ocFlag", ocFlag, 0);

    // R1: cut within the cycle, released at the next strobe
    @(negedge clk); cycleStrobe = 1'b1;
    @(negedge clk); cycleStrobe = 1'b0; ocDet = 1'b1;
    #0.5 chk("R1 same clock", hsCut, 1);
    @(negedge clk); ocDet = 1'b0;
    chk("R1 held", hsCut, 1);
    @(negedge clk);
    chk("R1 held later", hsCut, 1);
    cyc(0, 0);
    chk("R1 released", cutAtStart, 0);
    chk("R2 flag", ocFlag, 1);

    // R3/R4/R9 sweep over run length
    for (int n = 1; n <= 10; n++) begin
      doReset();
      repeat (n) cyc(1, 0);
      cyc(0, 0);
      chk("R3 enPullLow", enPullLow, (n >= 8) ? 1 : 0);
      chk("R3 regOff", regOff, (n >= 8) ? 1 : 0);
      chk("R2 flag after run", ocFlag, 1);
      if (n < 8) begin
        cyc(0, 0);
        chk("R4 flag cleared", ocFlag, 0);
        repeat (7) cyc(1, 0);
        cyc(0, 0);
        chk("R9 count restarted", enPullLow, 0);
      end
    end

    // R7: hiccup wait after overcurrent trip
    doReset();
    repeat (8) cyc(1, 0);
    cyc(0, 0);
    rc0 = restartCnt;
    for (int j = 1; j <= WAIT; j++) begin
      cyc(0, 0);
      if (j == 1) chk("R7 flag held in wait", ocFlag, 1);
      if (j == WAIT - 1) chk("R7 still waiting", enPullLow, 1);
      if (j == WAIT) begin
        chk("R7 released", enPullLow, 0);
        chk("R7 regOff released", regOff, 0);
        chk("R7 flag cleared", ocFlag, 0);
        chk("R7 one restart", restartCnt - rc0, 1);
      end
    end
    repeat (7) cyc(1, 0);
    cyc(0, 0);
    chk("R7 counters cleared", enPullLow, 0);

    // R6: undervoltage with no overcurrent, then R7 wait on that path
    doReset();
    cyc(0, 1);
    chk("R6 enPullLow", enPullLow, 1);
    chk("R6 regOff", regOff, 1);
    rc0 = restartCnt;
    repeat (WAIT - 1) cyc(0, 0);
    chk("R7 uv path waiting", enPullLow, 1);
    cyc(0, 0);
    chk("R7 uv path released", enPullLow, 0);
    chk("R7 uv path restart", restartCnt - rc0, 1);

    // R10: masked during soft-start
    doReset();
    ssDone = 1'b0;
    repeat (3) cyc(0, 1);
    chk("R10 masked", enPullLow, 0);
    ssDone = 1'b1;

    // R5: undervoltage after k counted overcurrent cycles
    for (int k = 1; k <= 5; k++) begin
      doReset();
      repeat (k) cyc(1, 0);
      cyc(0, 1);
      chk("R5 early trip", enPullLow, (k < 4) ? 1 : 0);
      if (k >= 4) chk("R5 flag kept", ocFlag, 1);
    end

    // R8: thermal sweep up then down
    doReset();
    rc0 = restartCnt;
    hotM = 1'b0;
    for (int t = 120; t <= 160; t++) begin
      @(negedge clk); tempCode = 8'(t);
      if (t >= 150) hotM = 1'b1; else if (t < 130) hotM = 1'b0;
      @(negedge clk);
      chk("R8 rising", regOff, int'(hotM));
    end
    for (int t = 160; t >= 120; t--) begin
      @(negedge clk); tempCode = 8'(t);
      if (t >= 150) hotM = 1'b1; else if (t < 130) hotM = 1'b0;
      @(negedge clk);
      chk("R8 falling", regOff, int'(hotM));
    end
    repeat (3) @(negedge clk);
    chk("R8 restart on cooling", restartCnt - rc0, 1);
    chk("R8 no pull-down", enPullLow, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule